// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a single-rank mobile SDRAM and moves the device into and out of its low-power self-refresh state. A sleep request first closes every bank with a precharge-all command and waits out the precharge time. If refresh bursts are enabled, it then sends a run of auto-refresh commands. Last, it issues the self-refresh entry command with clock enable driven low. While the device sleeps, only clock enable matters to it. The block holds clock enable low and deselects the device.

A wake request starts the exit. The block does not raise clock enable until the clock-stable input confirms the clock is good. After clock enable rises, it issues nothing but NOPs for the refresh-cycle time, so that any refresh the device began internally can finish. An optional second burst of auto-refreshes follows before the block reports ready. An acknowledge pulse marks both the entry and the return to ready. All nanosecond timings are given as parameters in picoseconds. They are turned into clock counts by ceiling division against the clock period.

Top module: `sr_seq`

## Requirements
- R1: In idle, a sleep request seen at a clock edge gives a precharge-all command in the next cycle: CS#=0, RAS#=0, CAS#=1, WE#=0 with A10=1.
- R2: The command after precharge-all comes exactly ceil(TRP_PS/CLK_PS) cycles after it (2 cycles at a 10 ns clock with 19 ns).
- R3: With bursts enabled, BURST_LEN auto-refresh commands (CS#=0, RAS#=0, CAS#=0, WE#=1, CKE=1) are issued before entry. Consecutive commands are spaced ceil(TRC_PS/CLK_PS) cycles apart.
- R4: Self-refresh entry uses the auto-refresh pin encoding with CKE=0 in the same cycle. It comes one refresh-cycle time after the last pre-entry refresh, or one precharge time after precharge-all when bursts are off.
- R5: In self-refresh, CKE stays 0 and CS#=1 until a wake request has been seen and clk_stable_i has been sampled high. CKE rises in the cycle after that sample.
- R6: From the cycle CKE rises, only NOPs (CS#=0, RAS#=1, CAS#=1, WE#=1) appear for ceil(TRC_PS/CLK_PS) cycles. The next command or acknowledge falls exactly at the end of that window.
- R7: With bursts enabled, BURST_LEN auto-refresh commands follow the exit window, spaced by the refresh-cycle time.
- R8: ack_o is high for exactly one cycle, in the entry-command cycle and in the ready cycle. Ready is one refresh-cycle time after the last post-exit refresh, or after CKE rises when bursts are off.
- R9: A sleep request that arrives outside idle is held. The precharge-all then comes two cycles after the ready acknowledge.
- R10: A wake request outside self-refresh has no effect: no command is issued and CKE does not change.
- R11: burst_en_i is sampled when the block leaves idle, and that value governs both the pre-entry and the post-exit bursts.
- R12: After reset, CKE=1, ack_o=0 and the pins carry a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to enter self-refresh |
| wake_req_i | input | 1 | Request to leave self-refresh |
| clk_stable_i | input | 1 | Device clock is confirmed stable |
| burst_en_i | input | 1 | Enable refresh bursts around self-refresh |
| ack_o | output | 1 | One-cycle pulse at entry and at ready |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| a10_o | output | 1 | Address bit 10, all-banks select for precharge |

## Verification
The assertions assume that reset is held low from time zero through the first edges. They also assume that clk_stable_i describes the clock in the cycle before clock enable rises. So the rule that clock enable rises only after a stable sample is checked against the input's previous value. The stimulus gives one-cycle request pulses and changes every input on the falling edge. It keeps clk_stable_i low from each sleep until a chosen delay into the wake. It sends wake pulses in idle and during the pre-entry burst, so the ignore rule is exercised at the pins rather than assumed.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_ALL,
    ST_WAIT_TRP,
    ST_PRE_BURST,
    ST_SR_ENTER,
    ST_IN_SR,
    ST_WAIT_CLK,
    ST_EXIT_NOP,
    ST_POST_BURST,
    ST_READY
  } sr_state_e;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_DESEL,
    CMD_PRE_ALL,
    CMD_REF,
    CMD_SR_ENTRY
  } sr_cmd_e;

  function automatic int unsigned cyc_ceil(input int unsigned dly_ps, input int unsigned clk_ps);
    return (dly_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sr_dly_timer.sv
module sr_dly_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sr_ref_ctr.sv
module sr_ref_ctr #(
  parameter int unsigned LEN = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/sr_cmd_enc.sv
module sr_cmd_enc
  import sr_seq_pkg::*;
(
  input  sr_cmd_e cmd_i,
  input  logic    cke_i,
  output logic    cs_n_o,
  output logic    ras_n_o,
  output logic    cas_n_o,
  output logic    we_n_o,
  output logic    cke_o,
  output logic    a10_o
);
  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
    a10_o = 1'b0;
    unique case (cmd_i)
      CMD_NOP:      {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
      CMD_DESEL:    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
      CMD_PRE_ALL: begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0010;
        a10_o = 1'b1;
      end
      CMD_REF,
      CMD_SR_ENTRY: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0001;
      default:      {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
    endcase
  end

  assign cke_o = cke_i;
endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned TRP_PS    = 19000,
  parameter int unsigned TRC_PS    = 67000,
  parameter int unsigned BURST_LEN = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic clk_stable_i,
  input  logic burst_en_i,
  output logic ack_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic cke_o,
  output logic a10_o
);
  localparam int unsigned TRP_CYC  = cyc_ceil(TRP_PS, CLK_PS);
  localparam int unsigned TRC_CYC  = cyc_ceil(TRC_PS, CLK_PS);
  // at least one wait cycle after precharge, at least one exit cycle (tSREX)
  localparam int unsigned TRP_WAIT = (TRP_CYC > 1) ? TRP_CYC - 1 : 1;
  localparam int unsigned TRC_N    = (TRC_CYC > 0) ? TRC_CYC : 1;
  localparam int unsigned TMAX     = (TRC_N > TRP_WAIT) ? TRC_N : TRP_WAIT;
  localparam int unsigned TW       = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TRP_LD = TW'(TRP_WAIT - 1);
  localparam logic [TW-1:0] TRC_LD = TW'(TRC_N - 1);

  sr_state_e     state_q, state_d;
  logic          sleep_q, burst_q;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic          bc_clr, bc_inc, bc_last;
  logic          ref_slot;
  sr_cmd_e       cmd;
  logic          cke_hi;

  sr_dly_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .cnt_o  (tmr_cnt),
    .zero_o (tmr_zero)
  );

  sr_ref_ctr #(.LEN(BURST_LEN)) u_refc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bc_clr),
    .inc_i  (bc_inc),
    .last_o (bc_last)
  );

  // refresh goes out in the first cycle of each tRC slot
  assign ref_slot = (tmr_cnt == TRC_LD);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    bc_clr   = 1'b0;
    bc_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (sleep_req_i || sleep_q) state_d = ST_PRE_ALL;
      ST_PRE_ALL: begin
        state_d  = ST_WAIT_TRP;
        tmr_load = 1'b1;
        tmr_val  = TRP_LD;
      end
      ST_WAIT_TRP:
        if (tmr_zero) begin
          if (burst_q) begin
            state_d  = ST_PRE_BURST;
            tmr_load = 1'b1;
            tmr_val  = TRC_LD;
            bc_clr   = 1'b1;
          end else begin
            state_d = ST_SR_ENTER;
          end
        end
      ST_PRE_BURST, ST_POST_BURST:
        if (tmr_zero) begin
          if (bc_last) begin
            state_d = (state_q == ST_PRE_BURST) ? ST_SR_ENTER : ST_READY;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = TRC_LD;
            bc_inc   = 1'b1;
          end
        end
      ST_SR_ENTER:
        state_d = ST_IN_SR;
      ST_IN_SR:
        if (wake_req_i) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK:
        if (clk_stable_i) begin
          state_d  = ST_EXIT_NOP;
          tmr_load = 1'b1;
          tmr_val  = TRC_LD;
        end
      ST_EXIT_NOP:
        if (tmr_zero) begin
          if (burst_q) begin
            state_d  = ST_POST_BURST;
            tmr_load = 1'b1;
            tmr_val  = TRC_LD;
            bc_clr   = 1'b1;
          end else begin
            state_d = ST_READY;
          end
        end
      ST_READY:
        state_d = ST_IDLE;
      default:
        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sleep_q <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) sleep_q <= 1'b0;
      else if (sleep_req_i)   sleep_q <= 1'b1;
      if (state_q == ST_IDLE && state_d == ST_PRE_ALL) burst_q <= burst_en_i;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    cke_hi = 1'b1;
    unique case (state_q)
      ST_PRE_ALL:                  cmd = CMD_PRE_ALL;
      ST_PRE_BURST, ST_POST_BURST: cmd = ref_slot ? CMD_REF : CMD_NOP;
      ST_SR_ENTER: begin
        cmd    = CMD_SR_ENTRY;
        cke_hi = 1'b0;
      end
      ST_IN_SR, ST_WAIT_CLK: begin
        cmd    = CMD_DESEL;
        cke_hi = 1'b0;
      end
      default:                     cmd = CMD_NOP;
    endcase
  end

  sr_cmd_enc u_enc (
    .cmd_i   (cmd),
    .cke_i   (cke_hi),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .cke_o   (cke_o),
    .a10_o   (a10_o)
  );

  assign ack_o = (state_q == ST_SR_ENTER) || (state_q == ST_READY);

  // ---------------- assertions ----------------
  logic          chk_cke_q;
  logic [TW-1:0] chk_win;
  logic          pins_nop;
  logic          cke_rise;

  assign pins_nop = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign cke_rise = cke_o && !chk_cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cke_q <= 1'b1;
      chk_win   <= '0;
    end else begin
      chk_cke_q <= cke_o;
      if (cke_rise)            chk_win <= TRC_LD;
      else if (chk_win != '0)  chk_win <= chk_win - 1'b1;
    end
  end

  p_ack_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_cke_needs_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));

  p_entry_encoding_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o));

  p_exit_nop_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_rise || chk_win != '0) |-> pins_nop);

  p_ref_with_cke_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o && cke_o) |-> $past(cke_o));

endmodule

// File: tb/sr_seq_tb_top.sv
module sr_seq_tb_top;
  localparam int unsigned CLK_PS = 10000;
  localparam int unsigned TRP_PS = 19000;
  localparam int unsigned TRC_PS = 67000;
  localparam int unsigned BLEN   = 4;
  localparam longint TRP = (TRP_PS + CLK_PS - 1) / CLK_PS; // 2
  localparam longint TRC = (TRC_PS + CLK_PS - 1) / CLK_PS; // 7

  localparam int EV_PRE  = 1;
  localparam int EV_REF  = 2;
  localparam int EV_SRE  = 3;
  localparam int EV_CKEH = 4;
  localparam int EV_ACK  = 5;
  localparam int EV_BAD  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req_i = 1'b0, wake_req_i = 1'b0, clk_stable_i = 1'b0, burst_en_i = 1'b0;
  logic ack_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, a10_o;

  always #5ns clk = ~clk;

  sr_seq #(.CLK_PS(CLK_PS), .TRP_PS(TRP_PS), .TRC_PS(TRC_PS), .BURST_LEN(BLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req_i), .wake_req_i(wake_req_i),
    .clk_stable_i(clk_stable_i), .burst_en_i(burst_en_i), .ack_o(ack_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .cke_o(cke_o), .a10_o(a10_o)
  );

  int     errors = 0;
  int     checks = 0;
  int     ev_count = 0;
  longint cyc = 0;
  bit     done = 1'b0;
  logic   cke_prev = 1'b1;

  int     kq[$];
  longint tq[$];
  string  rq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input longint t, input string req);
    kq.push_back(k);
    tq.push_back(t);
    rq.push_back(req);
  endtask

  task automatic ev(input int k);
    int     ek;
    longint et;
    string  er;
    ev_count++;
    if (kq.size() == 0) begin
      chk(1'b0, "R10", "unexpected event kind", k, 0);
    end else begin
      ek = kq.pop_front();
      et = tq.pop_front();
      er = rq.pop_front();
      chk(ek == k, er, "event kind", k, ek);
      chk(et == cyc, er, "event cycle", cyc, et);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic is_sre;
      is_sre = 1'b0;
      if (cke_o && !cke_prev) ev(EV_CKEH);
      if (!cs_n_o) begin
        case ({ras_n_o, cas_n_o, we_n_o})
          3'b010: ev(a10_o ? EV_PRE : EV_BAD);
          3'b001: begin
            if (cke_o) ev(EV_REF);
            else begin ev(EV_SRE); is_sre = 1'b1; end
          end
          3'b111: ;
          default: ev(EV_BAD);
        endcase
      end
      if (!cke_o && cke_prev && !is_sre) ev(EV_BAD);
      if (ack_o) ev(EV_ACK);
      cke_prev = cke_o;
    end
  end

  // expected entry sequence, precharge-all at cycle t
  task automatic push_entry(input longint t, input bit b);
    longint sre;
    push(EV_PRE, t, "R1");
    if (b) begin
      for (int i = 0; i < BLEN; i++)
        push(EV_REF, t + TRP + i * TRC, (i == 0) ? "R2" : "R3");
      sre = t + TRP + BLEN * TRC;
    end else begin
      sre = t + TRP;
    end
    push(EV_SRE, sre, b ? "R4" : "R2");
    push(EV_ACK, sre, "R8");
  endtask

  task automatic do_sleep(input bit b);
    @(negedge clk);
    clk_stable_i = 1'b0;
    burst_en_i = b;
    sleep_req_i = 1'b1;
    push_entry(cyc + 1, b);
    @(negedge clk);
    sleep_req_i = 1'b0;
  endtask

  task automatic do_wake(input int d, input bit b, output longint ack_t);
    longint c, ckeh;
    @(negedge clk);
    c = cyc;
    wake_req_i = 1'b1;
    if (d == 0) begin
      clk_stable_i = 1'b1;
      ckeh = c + 2;
      push(EV_CKEH, ckeh, "R5");
    end
    @(negedge clk);
    wake_req_i = 1'b0;
    if (d > 0) begin
      repeat (d - 1) @(negedge clk);
      clk_stable_i = 1'b1;
      ckeh = cyc + 1;
      push(EV_CKEH, ckeh, "R5");
    end
    if (b) begin
      for (int i = 0; i < BLEN; i++)
        push(EV_REF, ckeh + (i + 1) * TRC, (i == 0) ? "R6" : "R7");
      ack_t = ckeh + (BLEN + 1) * TRC;
      push(EV_ACK, ack_t, "R7");
    end else begin
      ack_t = ckeh + TRC;
      push(EV_ACK, ack_t, "R6");
    end
  endtask

  task automatic drain();
    while (kq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(kq.size() == 0, "R8", "queue drained", kq.size(), 0);
  endtask

  initial begin
    longint ack_t;
    int     n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cke_o == 1'b1, "R12", "cke after reset", cke_o, 1);
    chk(ack_o == 1'b0, "R12", "ack after reset", ack_o, 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R12", "nop after reset",
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);

    // no bursts, immediate stable clock
    do_sleep(1'b0);
    drain();
    do_wake(0, 1'b0, ack_t);
    drain();

    // bursts on both sides, clock stable late (R5)
    do_sleep(1'b1);
    drain();
    repeat (10) @(negedge clk);
    chk(cke_o == 1'b0 && cs_n_o == 1'b1, "R5", "cke low, deselected in self-refresh",
        {cke_o, cs_n_o}, 2'b01);
    do_wake(20, 1'b1, ack_t);
    drain();

    // R10: wake in idle ignored
    n0 = ev_count;
    @(negedge clk);
    wake_req_i = 1'b1;
    @(negedge clk);
    wake_req_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(ev_count == n0, "R10", "events after idle wake", ev_count - n0, 0);
    chk(cke_o == 1'b1, "R10", "cke after idle wake", cke_o, 1);

    // R11: burst config sampled at idle exit; R9: held sleep
    do_sleep(1'b1);
    drain();
    burst_en_i = 1'b0;
    do_wake(0, 1'b1, ack_t);
    while (cyc < ack_t - 10) @(negedge clk);
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    push_entry(ack_t + 2, 1'b0); // R9
    drain();
    do_wake(1, 1'b0, ack_t);
    drain();

    // R10: wake during pre-entry burst ignored
    do_sleep(1'b1);
    repeat (3) @(negedge clk);
    wake_req_i = 1'b1;
    @(negedge clk);
    wake_req_i = 1'b0;
    drain();
    repeat (30) @(negedge clk);
    chk(cke_o == 1'b0, "R10", "still in self-refresh after early wake", cke_o, 0);
    do_wake(3, 1'b1, ack_t);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule